// File: doc/BRIEF.md
# Same-ID Read Ordering Guard

This block sits on the read address path between one master and several slaves. It keeps track of every read transaction identifier that has reads in flight: how many reads are open under it and which slave they went to. Its job is to make sure that reads carrying the same identifier finish in the order they were issued, even when they are aimed at different slaves. It does this by holding back issue rather than by reordering returned data.

A read address that reuses an identifier already open at another slave is stalled until the earlier reads under that identifier have drained. Reads to the same slave under the same identifier pass, because a slave returns same-ID data in order. Reads with different identifiers never affect each other, so they may target different slaves at once and their data may interleave at the master. The surrounding interconnect supplies the decoded slave index with each address and a pulse on every last-beat handshake of a read burst, tagged with its identifier.

Top module: `rd_order_tracker`

## Requirements
- R1: After reset every per-ID count is zero, `ar_stall` is low and `underflow_err` is low.
- R2: An address whose ID has a count of zero is never stalled, whatever slave index it carries.
- R3: An address whose ID has a nonzero count below the maximum, and whose slave index equals the slave bound to that ID, is not stalled.
- R4: An address whose ID has a nonzero count and whose slave index differs from the slave bound to that ID is stalled.
- R5: An address whose ID count is at its maximum (all ones, 15 with the default 4-bit counter) is stalled even when it targets the bound slave.
- R6: The count and slave binding of one ID are not changed by addresses or completions carrying another ID, and a stall on one ID does not stall a different ID.
- R7: An address is accepted when `ar_valid` and `ar_ready` are high and `ar_stall` is low; an accepted address raises its ID count by one at the next clock edge, a completion pulse with a matching ID and nonzero count lowers it by one, and both in the same cycle leave it unchanged. Without acceptance the count does not move.
- R8: When an ID count returns to zero, its slave binding is released, so the next address under that ID may go to any slave and then binds that ID to the new slave.
- R9: A completion pulse for an ID whose count is zero sets `underflow_err` at the next edge; the flag stays high until reset and the count stays zero.
- R10: `ar_stall` is low whenever `ar_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ar_valid | input | 1 | Read address valid from the master |
| ar_ready | input | 1 | Ready from the decoded target slave |
| ar_id | input | ID_W (3) | Identifier of the offered read address |
| ar_slv | input | SLV_W (2) | Decoded slave index of the offered read address |
| r_last_done | input | 1 | Pulse on a last-beat read data handshake |
| r_done_id | input | ID_W (3) | Identifier of the completing read |
| ar_stall | output | 1 | Hold the offered address back this cycle |
| id_count | output | NUM_IDS*CNT_W (32) | Open-read count per ID; ID i occupies bits [i*CNT_W +: CNT_W] |
| underflow_err | output | 1 | Sticky flag for a completion with no open read |

## Verification
The bench goes after the cycle where a completion and a new address of the same ID meet: a design that applied only one of them would drift its count by one and later stall forever or release the binding early. It fills one ID to the counter limit, where a missing saturation stall would wrap the count to zero and let same-ID reads escape to another slave. It drains an ID to zero and re-issues to a new slave, which a design that kept the stale binding would stall for good, and it fires a completion on an idle ID, which a design without the guard would wrap to fifteen. Long mixed traffic over several IDs then checks that no ID's count leaks into another's.

// File: rtl/rot_pkg.sv
package rot_pkg;
    localparam int ROT_NUM_IDS = 8;
    localparam int ROT_NUM_SLV = 4;
    localparam int ROT_CNT_W   = 4;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_INC  = 2'd1,
        OP_DEC  = 2'd2
    } rot_op_e;
endpackage

// File: rtl/rot_id_entry.sv
module rot_id_entry
    import rot_pkg::*;
#(
    parameter int CNT_W = ROT_CNT_W,
    parameter int SLV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    input  logic [SLV_W-1:0] slv_in,
    output logic [CNT_W-1:0] cnt_o,
    output logic [SLV_W-1:0] slv_o,
    output logic             uflow_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SLV_W-1:0] slv;
    } ent_t;

    ent_t    st_d, st_q;
    rot_op_e op;
    logic    dec_ok;

    always_comb begin
        uflow_o = dec && (st_q.cnt == '0);
        dec_ok  = dec && (st_q.cnt != '0);
        if (inc && !dec_ok)      op = OP_INC;
        else if (dec_ok && !inc) op = OP_DEC;
        else                     op = OP_HOLD;
        st_d = st_q;
        case (op)
            OP_INC: begin
                st_d.cnt = st_q.cnt + 1'b1;
                st_d.slv = slv_in;
            end
            OP_DEC: begin
                st_d.cnt = st_q.cnt - 1'b1;
                if (st_q.cnt == CNT_W'(1)) st_d.slv = '0;
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign slv_o = st_q.slv;
endmodule

// File: rtl/rot_stall_check.sv
module rot_stall_check #(
    parameter int NUM_IDS = 8,
    parameter int CNT_W   = 4,
    parameter int SLV_W   = 2,
    localparam int ID_W   = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1
) (
    input  logic [NUM_IDS-1:0][CNT_W-1:0] cnt_all,
    input  logic [NUM_IDS-1:0][SLV_W-1:0] slv_all,
    input  logic                          ar_valid,
    input  logic [ID_W-1:0]               ar_id,
    input  logic [SLV_W-1:0]              ar_slv,
    output logic                          stall
);
    logic [CNT_W-1:0] sel_cnt;
    logic [SLV_W-1:0] sel_slv;
    logic             busy, other_slave, full;

    always_comb begin
        sel_cnt     = cnt_all[ar_id];
        sel_slv     = slv_all[ar_id];
        busy        = (sel_cnt != '0);
        other_slave = busy && (sel_slv != ar_slv);
        full        = (sel_cnt == {CNT_W{1'b1}});
        stall       = ar_valid && (other_slave || full);
    end
endmodule

// File: rtl/rd_order_tracker.sv
module rd_order_tracker
    import rot_pkg::*;
#(
    parameter int NUM_IDS = ROT_NUM_IDS,
    parameter int NUM_SLV = ROT_NUM_SLV,
    parameter int CNT_W   = ROT_CNT_W,
    localparam int ID_W   = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1,
    localparam int SLV_W  = (NUM_SLV > 1) ? $clog2(NUM_SLV) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ar_valid,
    input  logic                     ar_ready,
    input  logic [ID_W-1:0]          ar_id,
    input  logic [SLV_W-1:0]         ar_slv,
    input  logic                     r_last_done,
    input  logic [ID_W-1:0]          r_done_id,
    output logic                     ar_stall,
    output logic [NUM_IDS*CNT_W-1:0] id_count,
    output logic                     underflow_err
);
    logic [NUM_IDS-1:0][CNT_W-1:0] cnt_all;
    logic [NUM_IDS-1:0][SLV_W-1:0] slv_all;
    logic [NUM_IDS-1:0]            inc_vec, dec_vec, uflow_vec;
    logic                          accept;

    typedef struct packed {
        logic err;
    } top_st_t;

    top_st_t st_d, st_q;

    rot_stall_check #(
        .NUM_IDS(NUM_IDS), .CNT_W(CNT_W), .SLV_W(SLV_W)
    ) u_stall (
        .cnt_all (cnt_all),
        .slv_all (slv_all),
        .ar_valid(ar_valid),
        .ar_id   (ar_id),
        .ar_slv  (ar_slv),
        .stall   (ar_stall)
    );

    assign accept = ar_valid && ar_ready && !ar_stall;

    for (genvar i = 0; i < NUM_IDS; i++) begin : g_id
        assign inc_vec[i] = accept && (ar_id == ID_W'(i));
        assign dec_vec[i] = r_last_done && (r_done_id == ID_W'(i));

        rot_id_entry #(.CNT_W(CNT_W), .SLV_W(SLV_W)) u_entry (
            .clk    (clk),
            .rst_n  (rst_n),
            .inc    (inc_vec[i]),
            .dec    (dec_vec[i]),
            .slv_in (ar_slv),
            .cnt_o  (cnt_all[i]),
            .slv_o  (slv_all[i]),
            .uflow_o(uflow_vec[i])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.err = st_q.err || (|uflow_vec);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign id_count      = cnt_all;
    assign underflow_err = st_q.err;
endmodule

// File: rtl/rd_order_tracker_chk.sv
module rd_order_tracker_chk #(
    parameter int NUM_IDS = 8,
    parameter int CNT_W   = 4,
    parameter int ID_W    = 3,
    parameter int SLV_W   = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     ar_valid,
    input logic                     ar_ready,
    input logic [ID_W-1:0]          ar_id,
    input logic [SLV_W-1:0]         ar_slv,
    input logic                     r_last_done,
    input logic [ID_W-1:0]          r_done_id,
    input logic                     ar_stall,
    input logic [NUM_IDS*CNT_W-1:0] id_count,
    input logic                     underflow_err
);
    function automatic logic [CNT_W-1:0] cnt_of(input logic [ID_W-1:0] id);
        return id_count[id*CNT_W +: CNT_W];
    endfunction

    logic acc, same_done;
    assign acc       = ar_valid && ar_ready && !ar_stall;
    assign same_done = r_last_done && (r_done_id == ar_id);

    AST_FREE_ID: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid && (cnt_of(ar_id) == '0) |-> !ar_stall); // R2
    AST_SAT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid && (cnt_of(ar_id) == {CNT_W{1'b1}}) |-> ar_stall); // R5
    AST_INC_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !same_done |=> cnt_of($past(ar_id)) == CNT_W'($past(cnt_of(ar_id)) + 1'b1)); // R7
    AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        acc && same_done && (cnt_of(ar_id) != '0) |=> cnt_of($past(ar_id)) == $past(cnt_of(ar_id))); // R7
    AST_UFLOW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        r_last_done && (cnt_of(r_done_id) == '0) |=> underflow_err); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_err |=> underflow_err); // R9
    AST_NO_VALID_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !ar_valid |-> !ar_stall); // R10
endmodule

bind rd_order_tracker rd_order_tracker_chk #(
    .NUM_IDS(NUM_IDS), .CNT_W(CNT_W), .ID_W(ID_W), .SLV_W(SLV_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ar_valid     (ar_valid),
    .ar_ready     (ar_ready),
    .ar_id        (ar_id),
    .ar_slv       (ar_slv),
    .r_last_done  (r_last_done),
    .r_done_id    (r_done_id),
    .ar_stall     (ar_stall),
    .id_count     (id_count),
    .underflow_err(underflow_err)
);

// File: tb/rd_order_tracker_test.sv
`timescale 1ns/1ps
module rd_order_tracker_test;
    localparam int NI  = 8;
    localparam int CW  = 4;
    localparam int MAXC = 15;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ar_valid = 1'b0, ar_ready = 1'b0, r_last_done = 1'b0;
    logic [2:0] ar_id = '0, r_done_id = '0;
    logic [1:0] ar_slv = '0;
    logic       ar_stall, underflow_err;
    logic [NI*CW-1:0] id_count;

    int    errors = 0, checks = 0;
    bit    finished = 0;
    string phase = "reset";

    int q[NI][$];
    bit ref_err = 0;

    always #2 clk = ~clk;

    rd_order_tracker uut (
        .clk(clk), .rst_n(rst_n), .ar_valid(ar_valid), .ar_ready(ar_ready),
        .ar_id(ar_id), .ar_slv(ar_slv), .r_last_done(r_last_done),
        .r_done_id(r_done_id), .ar_stall(ar_stall), .id_count(id_count),
        .underflow_err(underflow_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s [%s] %s: actual=%0h expected=%0h", req, phase, what, act, exp);
        end
    endtask

    function automatic logic [NI*CW-1:0] ref_counts();
        logic [NI*CW-1:0] v = '0;
        for (int i = 0; i < NI; i++) v[i*CW +: CW] = CW'(q[i].size());
        return v;
    endfunction

    task automatic cyc(input bit v, input bit rdy, input int id, input int s,
                       input bit d, input int rid);
        bit    exp_stall, acc;
        string tag;
        @(negedge clk);
        ar_valid = v; ar_ready = rdy; ar_id = 3'(id); ar_slv = 2'(s);
        r_last_done = d; r_done_id = 3'(rid);
        #1;
        if (!v)                        begin exp_stall = 0; tag = "R10"; end
        else if (q[id].size() == 0)    begin exp_stall = 0; tag = "R2";  end
        else if (q[id].size() >= MAXC) begin exp_stall = 1; tag = "R5";  end
        else if (q[id][0] != s)        begin exp_stall = 1; tag = "R4";  end
        else                           begin exp_stall = 0; tag = "R3";  end
        chk(ar_stall == exp_stall, tag, "ar_stall", ar_stall, exp_stall);
        acc = v && rdy && !exp_stall;
        @(posedge clk);
        if (d) begin
            if (q[rid].size() == 0) ref_err = 1;
            else void'(q[rid].pop_front());
        end
        if (acc) q[id].push_back(s);
        #1;
        chk(id_count == ref_counts(), "R7", "id_count", id_count, ref_counts());
        chk(underflow_err == ref_err, "R9", "underflow_err", underflow_err, ref_err);
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #800000;
        checks++;
        errors++;
        $display("FAIL watchdog [%s]: actual=running expected=done", phase);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(id_count == '0, "R1", "id_count after reset", id_count, 0);
        chk(ar_stall == 1'b0, "R1", "ar_stall after reset", ar_stall, 0);
        chk(underflow_err == 1'b0, "R1", "underflow_err after reset", underflow_err, 0);

        phase = "R2 R3 bind id1 to slave2";
        repeat (3) cyc(1, 1, 1, 2, 0, 0);
        chk(id_count[1*CW +: CW] == 4'd3, "R3", "id1 count", id_count[1*CW +: CW], 3);

        phase = "R4 id1 to other slave";
        cyc(1, 1, 1, 0, 0, 0);
        chk(id_count[1*CW +: CW] == 4'd3, "R4", "id1 count after stall", id_count[1*CW +: CW], 3);

        phase = "R6 other id free";
        cyc(1, 1, 2, 0, 0, 0);
        cyc(1, 1, 3, 1, 0, 0);
        chk(id_count[1*CW +: CW] == 4'd3, "R6", "id1 unaffected", id_count[1*CW +: CW], 3);
        chk(id_count[2*CW +: CW] == 4'd1, "R6", "id2 count", id_count[2*CW +: CW], 1);

        phase = "R7 inc and dec same cycle";
        cyc(1, 1, 1, 2, 1, 1);
        chk(id_count[1*CW +: CW] == 4'd3, "R7", "id1 unchanged", id_count[1*CW +: CW], 3);
        cyc(1, 0, 1, 2, 0, 0);
        chk(id_count[1*CW +: CW] == 4'd3, "R7", "no accept without ready", id_count[1*CW +: CW], 3);

        phase = "R8 drain and rebind";
        repeat (3) cyc(0, 0, 0, 0, 1, 1);
        chk(id_count[1*CW +: CW] == 4'd0, "R8", "id1 drained", id_count[1*CW +: CW], 0);
        cyc(1, 1, 1, 3, 0, 0);
        chk(id_count[1*CW +: CW] == 4'd1, "R8", "id1 rebound to slave3", id_count[1*CW +: CW], 1);
        cyc(1, 1, 1, 2, 0, 0);
        chk(id_count[1*CW +: CW] == 4'd1, "R8", "old slave now stalled", id_count[1*CW +: CW], 1);

        phase = "R5 saturation";
        repeat (MAXC) cyc(1, 1, 5, 1, 0, 0);
        chk(id_count[5*CW +: CW] == 4'd15, "R5", "id5 at limit", id_count[5*CW +: CW], 15);
        cyc(1, 1, 5, 1, 0, 0);
        chk(id_count[5*CW +: CW] == 4'd15, "R5", "no wrap at limit", id_count[5*CW +: CW], 15);
        repeat (MAXC) cyc(0, 0, 0, 0, 1, 5);

        phase = "R9 underflow";
        chk(underflow_err == 1'b0, "R9", "no error yet", underflow_err, 0);
        cyc(0, 0, 0, 0, 1, 7);
        chk(id_count[7*CW +: CW] == 4'd0, "R9", "id7 stays zero", id_count[7*CW +: CW], 0);
        idle();
        idle();
        chk(underflow_err == 1'b1, "R9", "error sticky", underflow_err, 1);

        phase = "R6 mixed traffic";
        for (int n = 0; n < 3000; n++) begin
            int  rid = int'($urandom_range(NI-1, 0));
            bit  d   = ($urandom_range(2, 0) == 0) && (q[rid].size() != 0);
            cyc($urandom_range(3, 0) != 0, $urandom_range(4, 0) != 0,
                int'($urandom_range(NI-1, 0)), int'($urandom_range(3, 0)), d, rid);
        end

        finish_run();
    end
endmodule